// File: doc/BRIEF.md
# Sleep Mode Entry Controller

This block is the state machine that takes a device from normal running into one of four low-power states and brings it back. The processor's wait-for-interrupt strobe is the only way in. A small configuration register, written over a simple write port and readable back, holds a 3-bit depth code. A regulator-ready input must be high before either of the two middle depths may be entered. Each depth listens only to its own class of wake-up event. These range from any interrupt for the lightest state down to nothing but an external reset for the deepest.

The controller cannot be disabled and has no soft reset. Only the power-on reset initialises it. From its registered current mode it drives a processor clock enable, a bus clock enable and a vector of power-domain enables. It also reports the mode as a status field. A request for a gated depth made while the regulator is not ready leaves the device running and raises a sticky error flag.

Top module: `sleep_mode_ctrl`

## Requirements
- R1: After power-on reset, mode reads 0 (running), both clock enables are 1, every domain enable is 1, the error flag is 0 and the configuration readback is 0.
- R2: A configuration write appears on the readback at the first clock edge after the write cycle. A wait-for-interrupt in that same write cycle acts on the previous code.
- R3: A wait-for-interrupt while running moves the mode, at the next edge, to the configured code: 2 is the light sleep, 4 the standby, 5 the backup and 6 the off state. Any other code leaves the mode at 0 and does not set the error flag. Without a wait-for-interrupt the mode stays 0.
- R4: A wait-for-interrupt while in any sleep mode has no effect on the mode.
- R5: When regulator-ready is 0, a wait-for-interrupt with code 4 or 5 leaves the mode at 0 and sets the error flag. Codes 2 and 6 are not gated by regulator-ready.
- R6: The error flag stays at 1 until the next power-on reset.
- R7: The light sleep (2) returns to mode 0 at the next edge on a bus-clocked interrupt, a standby-capable peripheral interrupt or an asynchronous interrupt.
- R8: The standby mode (4) returns to 0 only on an asynchronous interrupt or a standby-capable peripheral interrupt. A plain bus-clocked interrupt is ignored.
- R9: The backup mode (5) returns to 0 only on the backup-reset input. The off mode (6) returns to 0 only on the external-reset input.
- R10: The processor clock enable is 1 only in mode 0. The bus clock enable is 1 only in modes 0 and 2. Domain enables are all 1 in modes 0, 2 and 4. In mode 5 only bit BKUP_DOM (default 0) is set. In mode 6 none is set.
- R11: Wake-up inputs have no effect while the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Depth code to write |
| cfg_rdata | output | 3 | Configuration readback |
| wfi | input | 1 | Wait-for-interrupt strobe |
| reg_ready | input | 1 | Low-power regulator has settled |
| irq_sync | input | 1 | Bus-clocked interrupt |
| irq_stby | input | 1 | Interrupt from a peripheral that runs in standby |
| irq_async | input | 1 | Asynchronous interrupt |
| backup_rst | input | 1 | Backup reset detected |
| ext_rst | input | 1 | External reset request |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| dom_en | output | NDOM | Power-domain enables |
| err_flag | output | 1 | Sticky gated-entry error |

## Verification
Every result is due exactly one clock edge after its stimulus. A mode change, a return to running, a readback update and the error flag are all registered once. The clock and domain enables follow the mode in the same cycle, with no further delay. The bench drives inputs and samples outputs one nanosecond after each rising edge, so each check reads the state set at the single edge since the stimulus was applied. A separate check confirms that a write and a wait-for-interrupt in the same cycle use the older code.

// File: rtl/sleep_mode_ctrl.sv
module sleep_mode_ctrl #(
  parameter int NDOM     = 4,
  parameter int BKUP_DOM = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_wdata,
  output logic [2:0]      cfg_rdata,
  input  logic            wfi,
  input  logic            reg_ready,
  input  logic            irq_sync,
  input  logic            irq_stby,
  input  logic            irq_async,
  input  logic            backup_rst,
  input  logic            ext_rst,
  output logic [2:0]      mode,
  output logic            cpu_clk_en,
  output logic            bus_clk_en,
  output logic [NDOM-1:0] dom_en,
  output logic            err_flag
);

  localparam logic [2:0] M_RUN  = 3'd0;
  localparam logic [2:0] M_IDLE = 3'd2;
  localparam logic [2:0] M_STBY = 3'd4;
  localparam logic [2:0] M_BKUP = 3'd5;
  localparam logic [2:0] M_OFF  = 3'd6;
  localparam logic [NDOM-1:0] ALL_DOM  = '1;
  localparam logic [NDOM-1:0] BKUP_MSK = NDOM'(1) << BKUP_DOM;

  logic [2:0] cfg_q, mode_q;
  logic       err_q;
  logic       code_ok, code_deep, wake;

  assign code_ok   = (cfg_q == M_IDLE) || (cfg_q == M_STBY) ||
                     (cfg_q == M_BKUP) || (cfg_q == M_OFF);
  assign code_deep = (cfg_q == M_STBY) || (cfg_q == M_BKUP);

  always_comb begin
    case (mode_q)
      M_IDLE:  wake = irq_sync | irq_stby | irq_async;
      M_STBY:  wake = irq_stby | irq_async;
      M_BKUP:  wake = backup_rst;
      M_OFF:   wake = ext_rst;
      default: wake = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= M_RUN;
      mode_q <= M_RUN;
      err_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (mode_q == M_RUN) begin
        if (wfi && code_ok) begin
          if (code_deep && !reg_ready) err_q <= 1'b1;
          else                         mode_q <= cfg_q;
        end
      end else if (wake) begin
        mode_q <= M_RUN;
      end
    end
  end

  assign cfg_rdata  = cfg_q;
  assign mode       = mode_q;
  assign err_flag   = err_q;
  assign cpu_clk_en = (mode_q == M_RUN);
  assign bus_clk_en = (mode_q == M_RUN) || (mode_q == M_IDLE);
  assign dom_en     = (mode_q == M_OFF)  ? '0 :
                      (mode_q == M_BKUP) ? BKUP_MSK : ALL_DOM;

  p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !wfi) |=> (mode_q == M_RUN));

  p_gate_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && wfi && code_deep && !reg_ready) |=> (mode_q == M_RUN && err_q));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_stby_sync_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STBY && !irq_async && !irq_stby) |=> (mode_q == M_STBY));

  p_bkup_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_BKUP && !backup_rst) |=> (mode_q == M_BKUP));

  p_off_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF && !ext_rst) |=> (mode_q == M_OFF));

  p_wfi_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN && !wake) |=> $stable(mode_q));

  p_clk_gating_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> (mode_q != M_RUN));

endmodule

// File: tb/tb_sleep_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_mode_ctrl;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, wfi = 0, reg_ready = 0;
  logic [2:0] cfg_wdata = 0;
  logic irq_sync = 0, irq_stby = 0, irq_async = 0, backup_rst = 0, ext_rst = 0;
  logic [2:0] cfg_rdata, mode;
  logic cpu_clk_en, bus_clk_en, err_flag;
  logic [3:0] dom_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sleep_mode_ctrl dut (.clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .wfi,
    .reg_ready, .irq_sync, .irq_stby, .irq_async, .backup_rst, .ext_rst,
    .mode, .cpu_clk_en, .bus_clk_en, .dom_en, .err_flag);

  // code, ready, wake {sync,stby,async,bkup,ext}, mode after wfi, mode after wake
  localparam logic [14:0] VEC [16] = '{
    {3'd2,1'b1,5'b10000,3'd2,3'd0}, {3'd2,1'b1,5'b00100,3'd2,3'd0},
    {3'd2,1'b1,5'b01000,3'd2,3'd0}, {3'd2,1'b1,5'b00010,3'd2,3'd2},
    {3'd4,1'b1,5'b10000,3'd4,3'd4}, {3'd4,1'b1,5'b01000,3'd4,3'd0},
    {3'd4,1'b1,5'b00100,3'd4,3'd0}, {3'd4,1'b1,5'b00001,3'd4,3'd4},
    {3'd5,1'b1,5'b00100,3'd5,3'd5}, {3'd5,1'b1,5'b00010,3'd5,3'd0},
    {3'd6,1'b1,5'b00010,3'd6,3'd6}, {3'd6,1'b1,5'b00001,3'd6,3'd0},
    {3'd6,1'b0,5'b00001,3'd6,3'd0}, {3'd2,1'b0,5'b00100,3'd2,3'd0},
    {3'd3,1'b1,5'b11111,3'd0,3'd0}, {3'd7,1'b1,5'b00000,3'd0,3'd0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_wake(input logic [4:0] w);
    {irq_sync, irq_stby, irq_async, backup_rst, ext_rst} = w;
  endtask

  task automatic write_cfg(input logic [2:0] c);
    cfg_we = 1; cfg_wdata = c; tick(); cfg_we = 0;
  endtask

  task automatic check_en(input logic [2:0] m, input string req);
    logic [3:0] ed;
    ed = (m == 6) ? 4'b0000 : (m == 5) ? 4'b0001 : 4'b1111;
    chk(cpu_clk_en == (m == 0), req, cpu_clk_en, m == 0);
    chk(bus_clk_en == (m == 0 || m == 2), req, bus_clk_en, m == 0 || m == 2);
    chk(dom_en == ed, req, dom_en, ed);
  endtask

  task automatic back_to_run();
    if (mode != 0) begin set_wake(5'b11111); tick(); set_wake(0); end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1; tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    chk(mode == 0, "R1 mode", mode, 0);
    chk(err_flag == 0, "R1 err", err_flag, 0);
    chk(cfg_rdata == 0, "R1 cfg", cfg_rdata, 0);
    check_en(3'd0, "R1 enables");

    // R3 code 0 with wfi stays running
    wfi = 1; tick(); wfi = 0;
    chk(mode == 0, "R3 invalid code 0", mode, 0);

    foreach (VEC[i]) begin
      write_cfg(VEC[i][14:12]);
      chk(cfg_rdata == VEC[i][14:12], "R2 readback", cfg_rdata, VEC[i][14:12]);
      reg_ready = VEC[i][11];
      tick();
      chk(mode == 0, "R3 no wfi stays running", mode, 0);
      wfi = 1; tick(); wfi = 0;
      chk(mode == VEC[i][5:3], "R3 entry", mode, VEC[i][5:3]);
      chk(err_flag == 0, "R3 no error", err_flag, 0);
      check_en(VEC[i][5:3], "R10 enables");
      set_wake(VEC[i][10:6]); tick(); set_wake(0);
      chk(mode == VEC[i][2:0], "R7 R8 R9 R11 wake", mode, VEC[i][2:0]);
      back_to_run();
      chk(mode == 0, "R7 R9 return", mode, 0);
    end
    reg_ready = 1;

    // R11 wakes ignored while running
    set_wake(5'b11111); tick(); set_wake(0);
    chk(mode == 0, "R11 wake while running", mode, 0);

    // R2 write and wfi in same cycle use old code (7 is invalid)
    write_cfg(3'd7);
    cfg_we = 1; cfg_wdata = 3'd2; wfi = 1; tick(); cfg_we = 0; wfi = 0;
    chk(mode == 0, "R2 same-cycle uses old code", mode, 0);
    chk(cfg_rdata == 2, "R2 new code visible", cfg_rdata, 2);
    wfi = 1; tick(); wfi = 0;
    chk(mode == 2, "R2 new code used next", mode, 2);

    // R4 wfi while asleep ignored
    write_cfg(3'd6);
    wfi = 1; tick(); wfi = 0;
    chk(mode == 2, "R4 wfi in sleep", mode, 2);
    back_to_run();

    // R5 gated entry
    reg_ready = 0; write_cfg(3'd4);
    wfi = 1; tick(); wfi = 0;
    chk(mode == 0, "R5 standby gated", mode, 0);
    chk(err_flag == 1, "R5 error set", err_flag, 1);
    write_cfg(3'd5);
    wfi = 1; tick(); wfi = 0;
    chk(mode == 0, "R5 backup gated", mode, 0);

    // R6 sticky across successful entry and wake
    reg_ready = 1;
    wfi = 1; tick(); wfi = 0;
    chk(mode == 5, "R6 entry after ready", mode, 5);
    chk(err_flag == 1, "R6 sticky asleep", err_flag, 1);
    back_to_run();
    tick();
    chk(err_flag == 1, "R6 sticky running", err_flag, 1);
    rst_n = 0; tick(); rst_n = 1; tick();
    chk(err_flag == 0, "R6 cleared by reset", err_flag, 0);
    chk(cfg_rdata == 0, "R1 cfg after reset", cfg_rdata, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule